// File: doc/BRIEF.md
# System Control and I/O Register Bank

This block is a small memory-mapped control region for a development board. Software reaches it through a simple word-wide register port covering a 4 KB window. A request is presented for one cycle and acknowledged on the next cycle, together with any read data. Behind the port sit a bank of LED drive bits, synchronized button and switch inputs, a general control word, an optional debug control word and two free-running time counters. One counter advances once per second and the other a hundred times per second. Both rates are derived from the system clock by internal dividers.

Three offsets are not stored locally. These are the event count, its reload value and the prescale count. Accesses to them are forwarded unchanged to an external prescaled counter through a narrow side port. This keeps that counter's timing logic out of the register bank. The LED field width and the presence of the debug and switch registers are build-time parameters. A register that is left out of the build decodes exactly like an empty offset.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, the LED register, `led_o`, the control word at 0x4C, the debug word at 0x04, and both time counters (0x10 and 0x14) all read zero.
- R2: A write to offset 0x00 stores only the low LED_W bits of the data. Reads return them zero-extended, and `led_o` bit i drives LED i active high. `led_o` changes only on a write to 0x00.
- R3: Offset 0x4C holds a full 32-bit control word that reads back exactly the value last written.
- R4: Offset 0x08 returns `btn_i` after a two-flop synchronizer, so an input that has been steady for two clock edges is visible to a read. Writes to 0x08 change nothing.
- R5: With HAS_DBG=1, offset 0x04 is a 32-bit read/write word. With HAS_SW=1, offset 0x28 returns `sw_i` through a two-flop synchronizer. When either parameter is 0, its offset behaves as unmapped.
- R6: Reads from an unmapped offset return zero, and writes to one change no state. Any address whose two low bits are not zero counts as unmapped, and accesses to such addresses never raise `ext_wr` or `ext_rd`.
- R7: The counter at 0x14 adds one every CLK_HZ/100 cycles and wraps from all ones to zero. A write loads the written value and restarts the interval, so the first increment comes one full interval after the write.
- R8: The counter at 0x10 adds one every CLK_HZ cycles. A write loads the written value and restarts the interval.
- R9: When a software write to a time counter coincides with its increment, the written value is stored and the increment is lost.
- R10: Offsets 0x18, 0x1C and 0x20 are forwarded to the side port with `ext_idx` equal to 0, 1 and 2 respectively. A write raises `ext_wr` with `ext_wdata` for one cycle, a read raises `ext_rd`, and the read returns `ext_rdata` sampled in the request cycle.
- R11: Every request cycle is followed by exactly one `rsp_ack` pulse in the next cycle, and there is no acknowledge without a request. `rsp_rdata` carries the read data for reads and zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with the acknowledge |
| btn_i | input | BTN_W | Asynchronous push-button levels |
| sw_i | input | SW_W | Asynchronous switch levels |
| led_o | output | LED_W | Active-high LED drive |
| ext_wr | output | 1 | Write strobe to the external prescaled counter |
| ext_rd | output | 1 | Read strobe to the external prescaled counter |
| ext_idx | output | 2 | External register index: 0 event count, 1 reload, 2 prescale count |
| ext_wdata | output | 32 | Write data to the external counter |
| ext_rdata | input | 32 | Read data from the external counter |

## Verification
The bench builds two copies side by side, both with CLK_HZ=1000, so the fast counter ticks every 10 cycles and the slow counter every 1000 cycles. This makes exact-cycle checks of the tick timing and of the write-versus-increment collision affordable. The first copy enables the debug and switch registers and uses a 3-bit LED field. The second copy disables both optional registers and keeps a 2-bit LED field. Running them together shows that the same write masks differently, and that the disabled offsets read zero while the enabled ones hold data.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    // Byte offsets that software decodes
    localparam logic [ADDR_W-1:0] OFS_LED   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_DBG   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_BTN   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SLOW  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_FAST  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_EVT   = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_RLD   = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_PSC   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_SW    = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_MISC  = 12'h04C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LED,
        SEL_DBG,
        SEL_BTN,
        SEL_SLOW,
        SEL_FAST,
        SEL_EXT,
        SEL_SW,
        SEL_MISC
    } reg_sel_e;

    typedef enum logic [1:0] {
        EXT_EVENT  = 2'd0,
        EXT_RELOAD = 2'd1,
        EXT_PSCNT  = 2'd2
    } ext_idx_e;

    typedef struct packed {
        reg_sel_e sel;
        ext_idx_e ext;
    } decode_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic decode_t decode_addr(logic [ADDR_W-1:0] a, bit has_dbg, bit has_sw);
        decode_t d;
        d.sel = SEL_NONE;
        d.ext = EXT_EVENT;
        if (a[1:0] == 2'b00) begin
            case (a)
                OFS_LED:  d.sel = SEL_LED;
                OFS_DBG:  d.sel = has_dbg ? SEL_DBG : SEL_NONE;
                OFS_BTN:  d.sel = SEL_BTN;
                OFS_SLOW: d.sel = SEL_SLOW;
                OFS_FAST: d.sel = SEL_FAST;
                OFS_EVT:  begin d.sel = SEL_EXT; d.ext = EXT_EVENT;  end
                OFS_RLD:  begin d.sel = SEL_EXT; d.ext = EXT_RELOAD; end
                OFS_PSC:  begin d.sel = SEL_EXT; d.ext = EXT_PSCNT;  end
                OFS_SW:   d.sel = has_sw ? SEL_SW : SEL_NONE;
                OFS_MISC: d.sel = SEL_MISC;
                default:  d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sysctl_tick_div.sv
module sysctl_tick_div #(
    parameter int unsigned DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    if (DIV > 1) begin : g_count
        logic [CW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst || restart_i)   cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
        assign tick_o = (cnt_q == LAST);
    end else begin : g_every
        assign tick_o = 1'b1;
    end
endmodule

// File: rtl/sysctl_timecnt.sv
module sysctl_timecnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst)         cnt_o <= '0;
        else if (load_i) cnt_o <= load_val_i;
        else if (inc_i)  cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned LED_W   = 2,
    parameter int unsigned BTN_W   = 4,
    parameter int unsigned SW_W    = 8,
    parameter bit          HAS_DBG = 1'b0,
    parameter bit          HAS_SW  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_ack,
    output logic [31:0]       rsp_rdata,
    input  logic [BTN_W-1:0]  btn_i,
    input  logic [SW_W-1:0]   sw_i,
    output logic [LED_W-1:0]  led_o,
    output logic              ext_wr,
    output logic              ext_rd,
    output logic [1:0]        ext_idx,
    output logic [31:0]       ext_wdata,
    input  logic [31:0]       ext_rdata
);
    localparam int unsigned SLOW_DIV = CLK_HZ;
    localparam int unsigned FAST_DIV = CLK_HZ / 100;

    bus_req_t req;
    decode_t  dec;
    logic     wr_hit, rd_hit;

    assign req = '{valid: req_valid, write: req_write, addr: req_addr, wdata: req_wdata};
    assign dec = decode_addr(req.addr, HAS_DBG, HAS_SW);
    assign wr_hit = req.valid &&  req.write;
    assign rd_hit = req.valid && !req.write;

    // Stored registers
    logic [LED_W-1:0]  led_q;
    logic [DATA_W-1:0] misc_q;
    logic [DATA_W-1:0] dbg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q  <= '0;
            misc_q <= '0;
            dbg_q  <= '0;
        end else if (wr_hit) begin
            case (dec.sel)
                SEL_LED:  led_q  <= req.wdata[LED_W-1:0];
                SEL_MISC: misc_q <= req.wdata;
                SEL_DBG:  dbg_q  <= req.wdata;
                default:  ;
            endcase
        end
    end

    assign led_o = led_q;

    // Input synchronizers
    logic [BTN_W-1:0] btn_s;
    logic [SW_W-1:0]  sw_s;

    sysctl_sync #(.W(BTN_W), .STAGES(2)) u_btn_sync (
        .clk(clk), .rst(rst), .d_i(btn_i), .q_o(btn_s)
    );
    sysctl_sync #(.W(SW_W), .STAGES(2)) u_sw_sync (
        .clk(clk), .rst(rst), .d_i(sw_i), .q_o(sw_s)
    );

    // Time counters
    logic              slow_load, fast_load, slow_tick, fast_tick;
    logic [DATA_W-1:0] slow_cnt, fast_cnt;

    assign slow_load = wr_hit && (dec.sel == SEL_SLOW);
    assign fast_load = wr_hit && (dec.sel == SEL_FAST);

    sysctl_tick_div #(.DIV(SLOW_DIV)) u_slow_div (
        .clk(clk), .rst(rst), .restart_i(slow_load), .tick_o(slow_tick)
    );
    sysctl_tick_div #(.DIV(FAST_DIV)) u_fast_div (
        .clk(clk), .rst(rst), .restart_i(fast_load), .tick_o(fast_tick)
    );
    sysctl_timecnt #(.W(DATA_W)) u_slow_cnt (
        .clk(clk), .rst(rst), .load_i(slow_load), .load_val_i(req.wdata),
        .inc_i(slow_tick), .cnt_o(slow_cnt)
    );
    sysctl_timecnt #(.W(DATA_W)) u_fast_cnt (
        .clk(clk), .rst(rst), .load_i(fast_load), .load_val_i(req.wdata),
        .inc_i(fast_tick), .cnt_o(fast_cnt)
    );

    // Side port to the external prescaled counter
    assign ext_wr    = wr_hit && (dec.sel == SEL_EXT);
    assign ext_rd    = rd_hit && (dec.sel == SEL_EXT);
    assign ext_idx   = 2'(dec.ext);
    assign ext_wdata = req.wdata;

    // Read mux
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        case (dec.sel)
            SEL_LED:  rd_mux = DATA_W'(led_q);
            SEL_DBG:  rd_mux = dbg_q;
            SEL_BTN:  rd_mux = DATA_W'(btn_s);
            SEL_SLOW: rd_mux = slow_cnt;
            SEL_FAST: rd_mux = fast_cnt;
            SEL_EXT:  rd_mux = ext_rdata;
            SEL_SW:   rd_mux = DATA_W'(sw_s);
            SEL_MISC: rd_mux = misc_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ack   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ack   <= req.valid;
            rsp_rdata <= rd_hit ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
    parameter int unsigned LED_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [11:0]      req_addr,
    input logic [31:0]      req_wdata,
    input logic             rsp_ack,
    input logic [LED_W-1:0] led_o,
    input logic             ext_wr,
    input logic             ext_rd,
    input logic             fast_load,
    input logic [31:0]      fast_cnt,
    input logic             slow_load,
    input logic [31:0]      slow_cnt
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (led_o == '0) && (fast_cnt == 32'd0) && (slow_cnt == 32'd0)); // R1

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_addr == 12'h000) |=> $stable(led_o)); // R2

    AST_MISALIGNED_NO_EXT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[1:0] != 2'b00) |-> (!ext_wr && !ext_rd)); // R6

    AST_FAST_STEP: assert property (@(posedge clk) disable iff (rst)
        !fast_load |=> (fast_cnt == $past(fast_cnt)) || (fast_cnt == $past(fast_cnt) + 32'd1)); // R7

    AST_SLOW_STEP: assert property (@(posedge clk) disable iff (rst)
        !slow_load |=> (slow_cnt == $past(slow_cnt)) || (slow_cnt == $past(slow_cnt) + 32'd1)); // R8

    AST_PRESET_WINS: assert property (@(posedge clk) disable iff (rst)
        fast_load |=> fast_cnt == $past(req_wdata)); // R9

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_ack); // R11

    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_ack); // R11
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.LED_W(LED_W)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(rsp_ack),
    .led_o(led_o), .ext_wr(ext_wr), .ext_rd(ext_rd),
    .fast_load(fast_load), .fast_cnt(fast_cnt),
    .slow_load(slow_load), .slow_cnt(slow_cnt)
);

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HZ = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  btn_i = '0;
    logic [7:0]  sw_i = '0;

    logic        ack_a, ack_b;
    logic [31:0] rd_a, rd_b;
    logic [2:0]  led_a;
    logic [1:0]  led_b;
    logic        ewr_a, erd_a, ewr_b, erd_b;
    logic [1:0]  eidx_a, eidx_b;
    logic [31:0] ewd_a, ewd_b, erd_data_a;
    logic [31:0] ext_mem [3];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regbank #(.CLK_HZ(HZ), .LED_W(3), .BTN_W(4), .SW_W(8),
                     .HAS_DBG(1'b1), .HAS_SW(1'b1)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(ack_a), .rsp_rdata(rd_a),
        .btn_i(btn_i), .sw_i(sw_i), .led_o(led_a), .ext_wr(ewr_a), .ext_rd(erd_a),
        .ext_idx(eidx_a), .ext_wdata(ewd_a), .ext_rdata(erd_data_a)
    );

    sysctl_regbank #(.CLK_HZ(HZ), .LED_W(2), .BTN_W(4), .SW_W(8),
                     .HAS_DBG(1'b0), .HAS_SW(1'b0)) dut_min_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(ack_b), .rsp_rdata(rd_b),
        .btn_i(btn_i), .sw_i(sw_i), .led_o(led_b), .ext_wr(ewr_b), .ext_rd(erd_b),
        .ext_idx(eidx_b), .ext_wdata(ewd_b), .ext_rdata(32'hFFFF_FFFF)
    );

    // Model of the external prescaled counter registers
    assign erd_data_a = (eidx_a < 2'd3) ? ext_mem[eidx_a] : 32'd0;
    always_ff @(posedge clk) begin
        if (rst) begin
            ext_mem[0] <= 32'd0; ext_mem[1] <= 32'd0; ext_mem[2] <= 32'd0;
        end else if (ewr_a && eidx_a < 2'd3) begin
            ext_mem[eidx_a] <= ewd_a;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(logic [11:0] a, output logic [31:0] da, output logic [31:0] db);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        da = rd_a; db = rd_b;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] a, b;
        bus_rd(12'h000, a, b); check("R1 led reg", a, 32'd0);
        check("R1 led_o", 32'(led_a), 32'd0);
        bus_rd(12'h04C, a, b); check("R1 misc", a, 32'd0);
        bus_rd(12'h010, a, b); check("R1 slow", a, 32'd0);
        bus_rd(12'h014, a, b); check("R1 fast", a, 32'd0);
        bus_rd(12'h004, a, b); check("R1 dbg", a, 32'd0);
    endtask

    task automatic t_ack();
        logic [31:0] a, b;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h04C;
        @(negedge clk);
        check("R11 ack after req", 32'(ack_a), 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R11 no stray ack", 32'(ack_a), 32'd0);
        bus_wr(12'h04C, 32'h1234_5678);
        check("R11 write data zero", rd_a, 32'd0);
        bus_rd(12'h04C, a, b);
    endtask

    task automatic t_led();
        logic [31:0] a, b;
        bus_wr(12'h000, 32'hFFFF_FFFD);
        bus_rd(12'h000, a, b);
        check("R2 led 3-bit mask", a, 32'd5);
        check("R2 led 2-bit mask", b, 32'd1);
        check("R2 led_o 3-bit", 32'(led_a), 32'd5);
        check("R2 led_o 2-bit", 32'(led_b), 32'd1);
    endtask

    task automatic t_misc();
        logic [31:0] a, b;
        bus_wr(12'h04C, 32'hA5C3_0F96);
        bus_rd(12'h04C, a, b);
        check("R3 misc readback", a, 32'hA5C3_0F96);
        bus_wr(12'h04C, 32'h8000_0001);
        bus_rd(12'h04C, a, b);
        check("R3 misc readback 2", a, 32'h8000_0001);
    endtask

    task automatic t_btn();
        logic [31:0] a, b;
        btn_i = 4'hA;
        idle(2);
        bus_rd(12'h008, a, b);
        check("R4 button read", a, 32'h0000_000A);
        bus_wr(12'h008, 32'h0000_0005);
        bus_rd(12'h008, a, b);
        check("R4 button write ignored", a, 32'h0000_000A);
        check("R4 led untouched", 32'(led_a), 32'd5);
    endtask

    task automatic t_optional();
        logic [31:0] a, b;
        bus_wr(12'h004, 32'hDEAD_BEEF);
        bus_rd(12'h004, a, b);
        check("R5 dbg enabled", a, 32'hDEAD_BEEF);
        check("R5 dbg disabled reads zero", b, 32'd0);
        sw_i = 8'h3C;
        idle(2);
        bus_rd(12'h028, a, b);
        check("R5 switch enabled", a, 32'h0000_003C);
        check("R5 switch disabled reads zero", b, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] a, b;
        bus_wr(12'h030, 32'hFFFF_FFFF);
        bus_rd(12'h030, a, b);
        check("R6 unmapped read", a, 32'd0);
        bus_rd(12'hFFC, a, b);
        check("R6 top of window", a, 32'd0);
        bus_wr(12'h04D, 32'h0BAD_0BAD);
        bus_rd(12'h04C, a, b);
        check("R6 misaligned write ignored", a, 32'h8000_0001);
        bus_rd(12'h04E, a, b);
        check("R6 misaligned read zero", a, 32'd0);
        bus_wr(12'h001, 32'h0000_0002);
        check("R6 misaligned led write", 32'(led_a), 32'd5);
        bus_wr(12'h019, 32'h0000_0077);
        bus_rd(12'h018, a, b);
        check("R6 misaligned ext write ignored", a, 32'd0);
    endtask

    task automatic t_fast();
        logic [31:0] a, b;
        bus_wr(12'h014, 32'h0000_0100);
        bus_rd(12'h014, a, b); check("R7 preset visible", a, 32'h0000_0100);
        idle(8);
        bus_rd(12'h014, a, b); check("R7 no tick before interval", a, 32'h0000_0100);
        bus_rd(12'h014, a, b); check("R7 tick after interval", a, 32'h0000_0101);
        idle(8);
        bus_wr(12'h014, 32'h0000_0040);
        bus_rd(12'h014, a, b); check("R9 preset wins over tick", a, 32'h0000_0040);
        idle(8);
        bus_rd(12'h014, a, b); check("R9 interval restarted", a, 32'h0000_0040);
        bus_rd(12'h014, a, b); check("R9 next tick", a, 32'h0000_0041);
        bus_wr(12'h014, 32'hFFFF_FFFF);
        idle(10);
        bus_rd(12'h014, a, b); check("R7 wrap to zero", a, 32'd0);
    endtask

    task automatic t_slow();
        logic [31:0] a, b;
        bus_wr(12'h010, 32'h0000_0007);
        bus_rd(12'h010, a, b); check("R8 preset visible", a, 32'h0000_0007);
        idle(998);
        bus_rd(12'h010, a, b); check("R8 no tick before interval", a, 32'h0000_0007);
        bus_rd(12'h010, a, b); check("R8 tick after interval", a, 32'h0000_0008);
    endtask

    task automatic t_ext();
        logic [31:0] a, b;
        bus_wr(12'h018, 32'h0000_0011);
        bus_wr(12'h01C, 32'h0000_0022);
        bus_wr(12'h020, 32'h0000_0033);
        check("R10 index 0 event", ext_mem[0], 32'h0000_0011);
        check("R10 index 1 reload", ext_mem[1], 32'h0000_0022);
        check("R10 index 2 prescale", ext_mem[2], 32'h0000_0033);
        bus_rd(12'h018, a, b); check("R10 read event", a, 32'h0000_0011);
        bus_rd(12'h01C, a, b); check("R10 read reload", a, 32'h0000_0022);
        bus_rd(12'h020, a, b); check("R10 read prescale", a, 32'h0000_0033);
        bus_wr(12'h000, 32'h0000_0002);
        check("R10 led write not forwarded", ext_mem[0], 32'h0000_0011);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ack();
        t_led();
        t_misc();
        t_btn();
        t_optional();
        t_unmapped();
        t_fast();
        t_slow();
        t_ext();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule